// File: doc/BRIEF.md
# Eight-Level Masked Interrupt Controller

The controller gathers a set of peripheral interrupt lines, sorts them into eight priority levels, and gives the CPU core one request. A rising edge on a source records its level in a pending register. This only happens if the level is not masked. Among the levels that are pending and unmasked, the one that comes first in a programmable rotating order wins. The core sees that level's number and a fast flag along with the request. When the core acknowledges, the pending bit of the level it was served is cleared.

Software reaches four byte-wide registers through a simple read/write port:

- **Pending** (write a 1 to clear a bit)
- **Mask**
- **Priority base**
- **System mode**: holds the global enable and the fast-level selection.

Vector fetch and context stacking are done outside this block.

Top module: `intc8_top`

## Requirements
- R1: After reset, every register reads 0 (pending, mask, priority base, system mode). While no new stimulus arrives, `irq_o` and `fast_o` stay 0.
- R2: Source k belongs to level k mod 8. A rising edge of a source whose level is unmasked sets that level's pending bit on the next clock edge. A source held high does not set the bit again after it has been cleared.
- R3: A mask bit of 1 disables its level. An edge on a masked level is discarded, and clearing the mask later does not bring it back. A level that is pending but masked never wins.
- R4: Priority base bits 2:0 name the top level. The order then runs base, base+1, … modulo 8. Bits 7:3 read back as 0.
- R5: `irq_o` is 1 only when global enable (system mode bit 0) is 1 and at least one level is pending and unmasked. `irq_lvl_o` then gives the winning level.
- R6: `fast_o` is 1 only when `irq_o` is 1, fast enable (system mode bit 4) is 1, and the winning level equals fast select (system mode bits 3:1).
- R7: `ack_i` while `irq_o` is 1 clears the pending bit of the level shown on `irq_lvl_o`. If an edge for the same level arrives in the same cycle, the bit stays set.
- R8: Writing the pending address clears every bit written as 1. An edge arriving on that level in the same cycle wins over the clear.
- R9: System mode bits 7:5 ignore writes and read back as 0.
- R10: Address 0 selects pending, 1 mask, 2 priority base, 3 system mode. `rdata_o` is a combinational read of the register that `addr_i` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Peripheral interrupt sources, captured on their rising edge |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| ack_i | input | 1 | Acknowledge from the core for the level presented |
| irq_o | output | 1 | Interrupt request to the core |
| irq_lvl_o | output | 3 | Winning level number |
| fast_o | output | 1 | Winning level is the enabled fast level |

## Verification
Two pairs of events can fall in the same cycle: a new source edge and the clearing of the same level's pending bit. The clear can come from the core's acknowledge or from a write-one-to-clear by software. The bench lines up each pair on one clock edge. It raises the level's source in the same cycle that the acknowledge or the write is driven. The bit must then read back as still set, and the level must still be requesting. Around those cases, the bench sweeps every priority base and fast selection against several pending patterns. It compares against a winner that it computes arithmetically from its own model.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
  localparam int N_LVL = 8;
  localparam int LVL_W = $clog2(N_LVL);

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1,
    REG_PRIO = 2'd2,
    REG_SYS  = 2'd3
  } reg_sel_e;

  // system mode: bit0 gie, bits 3:1 fast select, bit4 fast enable
  typedef struct packed {
    logic             fen;
    logic [LVL_W-1:0] fsel;
    logic             gie;
  } sys_t;

  localparam int SYS_W = $bits(sys_t);
endpackage

// File: rtl/intc8_regs.sv
module intc8_regs
  import intc8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [N_LVL-1:0] wdata_i,
  input  logic [N_LVL-1:0] pend_i,
  output logic [N_LVL-1:0] mask_o,
  output logic [LVL_W-1:0] base_o,
  output sys_t             sys_o,
  output logic [N_LVL-1:0] wclr_o,
  output logic [N_LVL-1:0] rdata_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      base_o <= '0;
      sys_o  <= '0;
    end else if (wr_en_i) begin
      case (sel)
        REG_MASK: mask_o <= wdata_i;
        REG_PRIO: base_o <= wdata_i[LVL_W-1:0];
        REG_SYS:  sys_o  <= sys_t'(wdata_i[SYS_W-1:0]);
        default:  ;
      endcase
    end
  end

  assign wclr_o = (wr_en_i && sel == REG_PEND) ? wdata_i : '0;

  always_comb begin
    case (sel)
      REG_PEND: rdata_o = pend_i;
      REG_MASK: rdata_o = mask_o;
      REG_PRIO: rdata_o = {{(N_LVL-LVL_W){1'b0}}, base_o};
      default:  rdata_o = {{(N_LVL-SYS_W){1'b0}}, sys_o};
    endcase
  end
endmodule

// File: rtl/intc8_pend.sv
module intc8_pend
  import intc8_pkg::*;
#(
  parameter int N_SRC = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_LVL-1:0] mask_i,
  input  logic [N_LVL-1:0] wclr_i,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  output logic [N_LVL-1:0] pend_o
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] rise;
  logic [N_LVL-1:0] lvl_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  assign rise = src_i & ~src_q;

  always_comb begin
    lvl_evt = '0;
    for (int k = 0; k < N_SRC; k++)
      if (rise[k]) lvl_evt[k % N_LVL] = 1'b1;
  end

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    logic clr, set;
    assign clr = wclr_i[l] | (ack_i && ack_lvl_i == LVL_W'(l));
    assign set = lvl_evt[l] & ~mask_i[l];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[l] <= 1'b0;
      else if (set)      pend_o[l] <= 1'b1;
      else if (clr)      pend_o[l] <= 1'b0;
    end

    assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_o[l] && !lvl_evt[l]) |=> !pend_o[l]);

    assert_masked_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_o[l] && mask_i[l]) |=> !pend_o[l]);
  end

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !lvl_evt[ack_lvl_i]) |=> !pend_o[$past(ack_lvl_i)]);
endmodule

// File: rtl/intc8_arb.sv
module intc8_arb
  import intc8_pkg::*;
(
  input  logic [N_LVL-1:0] pend_i,
  input  logic [N_LVL-1:0] mask_i,
  input  logic [LVL_W-1:0] base_i,
  input  sys_t             sys_i,
  output logic             irq_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             fast_o
);
  logic [N_LVL-1:0] req;
  logic             any;

  assign req = pend_i & ~mask_i;
  assign any = |req;

  // scan from lowest priority up so the top-ranked hit is written last
  always_comb begin
    lvl_o = '0;
    for (int k = N_LVL - 1; k >= 0; k--) begin
      if (req[LVL_W'((int'(base_i) + k) % N_LVL)])
        lvl_o = LVL_W'((int'(base_i) + k) % N_LVL);
    end
  end

  assign irq_o  = any & sys_i.gie;
  assign fast_o = irq_o & sys_i.fen & (lvl_o == sys_i.fsel);
endmodule

// File: rtl/intc8_top.sv
module intc8_top
  import intc8_pkg::*;
#(
  parameter int N_SRC = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic [N_LVL-1:0] wdata_i,
  output logic [N_LVL-1:0] rdata_o,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic             fast_o
);
  logic [N_LVL-1:0] pend, mask, wclr;
  logic [LVL_W-1:0] base;
  sys_t             sys;

  intc8_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .pend_i (pend),
    .mask_o (mask),
    .base_o (base),
    .sys_o  (sys),
    .wclr_o (wclr),
    .rdata_o
  );

  intc8_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i, .rst_ni, .src_i,
    .mask_i    (mask),
    .wclr_i    (wclr),
    .ack_i     (ack_i & irq_o),
    .ack_lvl_i (irq_lvl_o),
    .pend_o    (pend)
  );

  intc8_arb u_arb (
    .pend_i (pend),
    .mask_i (mask),
    .base_i (base),
    .sys_i  (sys),
    .irq_o,
    .lvl_o  (irq_lvl_o),
    .fast_o
  );

  assert_win_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend[irq_lvl_o] && !mask[irq_lvl_o]));

  assert_top_level_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && pend[base] && !mask[base]) |-> (irq_lvl_o == base));

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sys.gie);

  assert_fast_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |-> (irq_o && sys.fen && irq_lvl_o == sys.fsel));
endmodule

// File: tb/intc8_top_test.sv
module intc8_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 27;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NS-1:0] src = '0;
  logic [1:0]    addr = '0;
  logic          wr_en = 0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          ack = 0;
  logic          irq;
  logic [2:0]    lvl;
  logic          fast;

  int n_chk = 0, n_bad = 0;
  logic [7:0] e_pend = 0, e_mask = 0;
  logic [2:0] e_base = 0;
  logic [4:0] e_sys = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc8_top #(.N_SRC(NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .irq_o(irq),
    .irq_lvl_o(lvl), .fast_o(fast)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    cyc();
    wr_en = 0;
    case (a)
      2'd0: e_pend &= ~d;
      2'd1: e_mask = d;
      2'd2: e_base = d[2:0];
      default: e_sys = d[4:0];
    endcase
  endtask

  task automatic pulse(int k);
    src[k] = 1; cyc(); src[k] = 0; cyc();
    if (!e_mask[k % 8]) e_pend[k % 8] = 1;
  endtask

  function automatic void model(output logic m_irq, output logic [2:0] m_lvl, output logic m_fast);
    m_irq = 0; m_lvl = 0;
    for (int k = 0; k < 8; k++) begin
      int l = (e_base + k) % 8;
      if (!m_irq && e_pend[l] && !e_mask[l]) begin m_irq = 1; m_lvl = 3'(l); end
    end
    m_irq  = m_irq & e_sys[0];
    m_fast = m_irq && e_sys[4] && m_lvl == e_sys[3:1];
  endfunction

  task automatic chk_out(string tag);
    logic m_irq, m_fast; logic [2:0] m_lvl;
    model(m_irq, m_lvl, m_fast);
    chk({tag, " irq"}, irq, m_irq);
    if (m_irq) chk({tag, " lvl"}, lvl, m_lvl);
    chk({tag, " fast"}, fast, m_fast);
  endtask

  task automatic do_ack();
    logic m_irq, m_fast; logic [2:0] m_lvl;
    model(m_irq, m_lvl, m_fast);
    ack = 1; cyc(); ack = 0;
    if (m_irq) e_pend[m_lvl] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R1 reset state
    rd(0, 0, "R1 pend"); rd(1, 0, "R1 mask"); rd(2, 0, "R1 prio"); rd(3, 0, "R1 sys");
    chk("R1 irq", irq, 0); chk("R1 fast", fast, 0);

    // R2 / R10 source-to-level map, R8 clear by write
    for (int k = 0; k < NS; k++) begin
      pulse(k);
      rd(0, 8'(1 << (k % 8)), "R2 map");
      wr(0, 8'hFF);
      rd(0, 8'h00, "R8 w1c");
    end
    // R2 held source does not re-set
    src[3] = 1; cyc(); e_pend[3] = 1;
    rd(0, e_pend, "R2 held set");
    wr(0, 8'h08); cyc(); cyc();
    rd(0, 8'h00, "R2 held no reset");
    src[3] = 0; cyc();

    // R3 masked edges dropped
    wr(1, 8'h55);
    rd(1, 8'h55, "R10 mask rd");
    for (int k = 0; k < 8; k++) pulse(k);
    rd(0, 8'hAA, "R3 drop");
    wr(1, 8'h00);
    rd(0, 8'hAA, "R3 no revive");
    wr(3, 8'h01);
    for (int k = 0; k < 8; k++) pulse(k + 8);
    wr(1, 8'hFF);
    chk_out("R3 all masked");
    wr(1, 8'h00);

    // R4/R5/R6 sweep
    begin
      logic [7:0] pats [4] = '{8'hFF, 8'h81, 8'h24, 8'h10};
      for (int p = 0; p < 4; p++)
        for (int b = 0; b < 8; b++) begin
          wr(0, 8'hFF);
          for (int l = 0; l < 8; l++) if (pats[p][l]) pulse(l + 16 < NS ? l + 16 : l);
          wr(2, 8'(b));
          wr(1, 8'(1 << ((b + 1) % 8)));
          for (int s = 0; s < 8; s++) begin
            wr(3, 8'(5'h11 | (s << 1)));
            chk_out("R4 R6 sweep");
          end
          wr(3, 8'(5'h01 | (b << 1)));
          chk_out("R6 fen off");
          wr(3, 8'h10 | 8'(b << 1));
          chk_out("R5 gie off");
        end
    end
    rd(2, 8'h07, "R4 prio rd");
    wr(2, 8'hFF); rd(2, 8'h07, "R4 upper bits");
    wr(3, 8'hFF); rd(3, 8'h1F, "R9 unused");

    // R7 ack walks through all levels
    wr(1, 8'h00); wr(2, 8'h05); wr(3, 8'h01);
    for (int k = 0; k < 8; k++) pulse(k);
    for (int k = 0; k < 9; k++) begin
      chk_out("R7 ack walk");
      do_ack();
    end
    rd(0, 8'h00, "R7 drained");

    // R7 collision: ack and new edge on same level
    wr(2, 8'h02);
    pulse(2);
    chk_out("R7 pre");
    src[10] = 1; ack = 1; cyc(); ack = 0; src[10] = 0; cyc();
    rd(0, 8'h04, "R7 set wins");
    chk_out("R7 still req");

    // R8 collision: write clear and edge same cycle
    src[18] = 1; addr = 0; wdata = 8'h04; wr_en = 1; cyc(); wr_en = 0; src[18] = 0; cyc();
    rd(0, 8'h04, "R8 set wins");
    wr(0, 8'h04);
    rd(0, 8'h00, "R8 cleared");
    chk_out("R5 idle");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule